// File: doc/BRIEF.md
# Four-Channel Serial Converter Register Front End

This block is the digital register front end of a four-channel, 14-bit converter. A host writes 16-bit words over a three-wire serial link made of an active-low select, a serial clock and a data line. Each word carries a 2-bit channel address followed by a 14-bit code. When the select line rises, the code is written into the input register of the addressed channel. A separate active-low load strobe, which acts on its level, copies all four input registers into the four output registers at once. Holding the strobe low makes the output registers follow the input registers. The four output codes are the block's outputs and feed the analog converters.

The serial pins are sampled in the block's own clock domain, so the serial clock must be slower than half the system clock. An edge detector turns the serial clock and the select line into single-cycle strobes. A serial output repeats the input stream after a fixed delay, so several devices can share one chain. A power-on reset and an external reset both act asynchronously. Either one presets every input and output register to zero or to half-scale, as chosen by a preset-select pin.

Top module: `quad_dac_serial_if`

## Requirements
- R1: While `porN` or `rsN` is low, every input register and every output register holds the preset code: 0x0000 when `presetHalf` is 0 and 0x2000 when it is 1. Once both resets are high, a change of `presetHalf` has no effect on any register.
- R2: The shift register takes in one `sdi` bit on each rising edge of `sclk` seen while `csN` is low. While `csN` is high it holds its contents, whatever happens on `sclk` and `sdi`.
- R3: A rising edge of `csN` writes shift-register bits 13..0 into one input register, chosen by bits 15..14 (bit 15 is the high address bit): 00 selects channel 0, 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3. No input register changes at any other time, apart from reset.
- R4: When more than 16 bits are shifted during one low period of `csN`, only the last 16 bits are used. The first bit of those 16 becomes bit 15.
- R5: When fewer than 16 bits are shifted before `csN` rises, the current shift-register contents are loaded as they are. These are the new bits shifted in below the older ones, and no bit count is checked.
- R6: While `loadN` is low, each output register takes the value of its input register on the next clock. While `loadN` is high, the output registers hold.
- R7: `loadN` acts whatever the state of `csN`, including in the middle of a serial transfer.
- R8: `sdo` changes only when a bit is shifted in. After the k-th shift it shows the bit that was shifted in at shift k-16, so a bit entering on `sdi` leaves on `sdo` at the 17th serial clock edge counted from its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| rsN | input | 1 | External reset, asynchronous, active low |
| presetHalf | input | 1 | Preset select: 0 presets to zero, 1 to half-scale |
| csN | input | 1 | Serial select, active low; its rising edge loads an input register |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in, address first, most significant bit first |
| loadN | input | 1 | Load strobe, active low, level-sensitive |
| sdo | output | 1 | Serial data out for chaining |
| dacOut | output | 56 | Four output codes; channel c occupies bits 14c+13..14c |

## Verification
On every cycle the assertions check that the shift register and `sdo` stay still while the select line is high or no serial edge arrives, that input registers change only on a load pulse, that output registers hold while the strobe is high and copy on the next clock while it is low, and that `sdo` carries the previous top shift-register bit. The address decode, the handling of over-length and short words, the reset presets and their selection, the full 17-edge chain delay and the strobe firing in the middle of a transfer can only be shown by the bench's scenarios. The bench sweeps every channel with several codes and compares the results against a reference shift register of its own.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

  // Single-cycle strobes sent from the serial control to the datapath
  typedef struct packed {
    logic shiftEn;  // take one sdi bit into the shift register
    logic loadEn;   // select rose: write the addressed input register
  } serStrobe_t;

endpackage

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import quad_dac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  output serStrobe_t strb
);

  logic sclkQ;
  logic csQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
    end
  end

  always_comb begin
    strb.shiftEn = sclk & ~sclkQ & ~csN;
    strb.loadEn  = csN & ~csQ;
  end

  // R3: one load pulse per rising edge of the select line
  p_single_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> !strb.loadEn);

endmodule

// File: rtl/quad_dac_datapath.sv
module quad_dac_datapath
  import quad_dac_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            presetHalf,
  input  logic                            sdi,
  input  logic                            loadN,
  input  serStrobe_t                      strb,
  output logic                            sdo,
  output logic [(1<<ADDR_W)*DATA_W-1:0]   dacOut
);

  localparam int NCH    = 1 << ADDR_W;
  localparam int WORD_W = ADDR_W + DATA_W;

  logic [WORD_W-1:0]            shiftReg;
  logic                         sdoReg;
  logic [ADDR_W-1:0]            chanSel;
  logic [DATA_W-1:0]            presetVal;
  logic [NCH-1:0][DATA_W-1:0]   inAll;
  logic [NCH-1:0][DATA_W-1:0]   dacAll;

  assign presetVal = {presetHalf, {(DATA_W-1){1'b0}}};
  assign chanSel   = shiftReg[WORD_W-1 -: ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= 1'b0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[WORD_W-2:0], sdi};
      sdoReg   <= shiftReg[WORD_W-1];
    end
  end

  assign sdo = sdoReg;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [DATA_W-1:0] inQ;
    logic [DATA_W-1:0] dacQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        inQ <= presetVal;
      else if (strb.loadEn && (chanSel == ADDR_W'(c)))
        inQ <= shiftReg[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        dacQ <= presetVal;
      else if (!loadN)
        dacQ <= inQ;
    end

    assign inAll[c]  = inQ;
    assign dacAll[c] = dacQ;
    assign dacOut[c*DATA_W +: DATA_W] = dacQ;
  end

  // R2: shift register still when no serial edge is taken
  p_sreg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(shiftReg));

  // R3: input registers change only on a load pulse
  p_in_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> $stable(inAll));

  // R6: output registers hold while the strobe is high
  p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> $stable(dacAll));

  // R6: output registers copy input registers while the strobe is low
  p_dac_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> (dacAll == $past(inAll)));

  // R8: sdo carries the top shift-register bit from before the shift
  p_sdo_lag_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (sdo == $past(shiftReg[WORD_W-1])));

endmodule

// File: rtl/quad_dac_serial_if.sv
module quad_dac_serial_if
  import quad_dac_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          porN,
  input  logic                          rsN,
  input  logic                          presetHalf,
  input  logic                          csN,
  input  logic                          sclk,
  input  logic                          sdi,
  input  logic                          loadN,
  output logic                          sdo,
  output logic [(1<<ADDR_W)*DATA_W-1:0] dacOut
);

  logic       rstN;
  serStrobe_t strb;

  assign rstN = porN & rsN;

  quad_dac_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .strb (strb)
  );

  quad_dac_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .presetHalf (presetHalf),
    .sdi        (sdi),
    .loadN      (loadN),
    .strb       (strb),
    .sdo        (sdo),
    .dacOut     (dacOut)
  );

  // R2: sdo stays quiet while the select line is high
  p_sdo_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(sdo));

endmodule

// File: tb/tb_quad_dac_serial_if.sv
module tb_quad_dac_serial_if;

  logic clk = 1'b0;
  logic porN, rsN, presetHalf, csN, sclk, sdi, loadN;
  logic sdo;
  logic [55:0] dacOut;

  int checks = 0;
  int errors = 0;
  logic [13:0] expIn  [4];
  logic [13:0] expDac [4];
  logic [15:0] sm;

  always #2.5 clk = ~clk;

  quad_dac_serial_if dut (
    .clk(clk), .porN(porN), .rsN(rsN), .presetHalf(presetHalf),
    .csN(csN), .sclk(sclk), .sdi(sdi), .loadN(loadN),
    .sdo(sdo), .dacOut(dacOut)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkDac(string tag);
    for (int c = 0; c < 4; c++)
      chk($sformatf("%s ch%0d", tag, c), 32'(dacOut[c*14 +: 14]), 32'(expDac[c]));
  endtask

  task automatic csLow();
    csN = 1'b0; tick();
  endtask

  task automatic csHigh();
    csN = 1'b1; tick();
    expIn[sm[15:14]] = sm[13:0];
  endtask

  task automatic shiftBit(logic b);
    sdi = b; sclk = 1'b1; tick();
    sclk = 1'b0; tick();
    sm = {sm[14:0], b};
  endtask

  task automatic pulseLoad();
    loadN = 1'b0; tick();
    loadN = 1'b1; tick();
    for (int c = 0; c < 4; c++) expDac[c] = expIn[c];
  endtask

  task automatic writeWord(logic [15:0] w);
    csLow();
    for (int i = 15; i >= 0; i--) shiftBit(w[i]);
    csHigh();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [39:0] pat;
    porN = 1'b0; rsN = 1'b1; presetHalf = 1'b0;
    csN = 1'b1; sclk = 1'b0; sdi = 1'b0; loadN = 1'b1;
    sm = '0;
    for (int c = 0; c < 4; c++) begin expIn[c] = '0; expDac[c] = '0; end
    repeat (3) tick();
    checkDac("R1 power-on zero preset");
    porN = 1'b1; tick();

    // R1: external reset with half-scale preset
    rsN = 1'b0; presetHalf = 1'b1; tick(); tick();
    for (int c = 0; c < 4; c++) begin expIn[c] = 14'h2000; expDac[c] = 14'h2000; end
    checkDac("R1 reset half preset");
    rsN = 1'b1; tick();
    presetHalf = 1'b0; tick();
    pulseLoad();
    checkDac("R1 input regs half preset, select change ignored");
    sm = '0;

    // R8: chain delay of 17 serial edges from a cleared shift register
    pat = 40'hA5_3C96_E18F;
    csLow();
    for (int k = 1; k <= 40; k++) begin
      shiftBit(pat[40-k]);
      chk($sformatf("R8 sdo after shift %0d", k), 32'(sdo),
          (k >= 17) ? 32'(pat[40-(k-16)]) : 32'd0);
    end
    csHigh();
    pulseLoad();
    checkDac("R4 long stream in R8 test");

    // R3: every channel with several codes; R6 hold before strobe
    for (int ch = 0; ch < 4; ch++) begin
      for (int v = 0; v < 4; v++) begin
        logic [13:0] d;
        case (v)
          0: d = 14'h0000;
          1: d = 14'h3FFF;
          default: d = 14'((v * 32'h1357 + ch * 32'h0A1) & 32'h3FFF);
        endcase
        writeWord({2'(ch), d});
        checkDac("R6 outputs hold while strobe high");
        pulseLoad();
        chk($sformatf("R3 decode ch%0d", ch), 32'(dacOut[ch*14 +: 14]), 32'(d));
        checkDac("R3 decode all channels");
      end
    end

    // R4: 24 bits in one select period, last 16 used
    csLow();
    for (int i = 0; i < 8; i++) shiftBit(1'b1);
    for (int i = 15; i >= 0; i--) shiftBit(16'h4ABC >> i);
    csHigh();
    pulseLoad();
    chk("R4 last 16 bits ch1", 32'(dacOut[14 +: 14]), 32'h0ABC);
    checkDac("R4 over-length word");

    // R5: short word loads shifted contents as they stand
    writeWord(16'hC321);
    csLow();
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1); shiftBit(1'b1);
    csHigh();
    pulseLoad();
    chk("R5 short word ch0", 32'(dacOut[0 +: 14]), 32'h321B);
    chk("R5 short word ch3 kept", 32'(dacOut[42 +: 14]), 32'h0321);
    checkDac("R5 short word");

    // R2: serial edges with select high are ignored
    for (int i = 0; i < 16; i++) begin
      sdi = 1'b1; sclk = 1'b1; tick(); sclk = 1'b0; tick();
    end
    chk("R2 sdo unchanged with select high", 32'(sdo), 32'(sm[15]));
    csLow();
    csHigh();
    pulseLoad();
    chk("R2 ch3 untouched", 32'(dacOut[42 +: 14]), 32'h0321);
    checkDac("R2 shift register held");

    // R7: strobe fires in the middle of a transfer
    writeWord(16'h9111);
    csLow();
    for (int i = 0; i < 5; i++) shiftBit(i[0]);
    loadN = 1'b0; tick();
    loadN = 1'b1; tick();
    for (int c = 0; c < 4; c++) expDac[c] = expIn[c];
    chk("R7 ch2 loaded with select low", 32'(dacOut[28 +: 14]), 32'h1111);
    checkDac("R7 strobe independent of select");
    csHigh();
    pulseLoad();
    checkDac("R7 after transfer ends");

    // R6: strobe held low, outputs follow input registers
    loadN = 1'b0;
    writeWord(16'h6222);
    tick();
    for (int c = 0; c < 4; c++) expDac[c] = expIn[c];
    chk("R6 transparent ch1", 32'(dacOut[14 +: 14]), 32'h2222);
    checkDac("R6 transparent");
    loadN = 1'b1; tick();

    summary();
    $finish;
  end

endmodule